// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block runs one operation at a time against a parallel NOR flash that uses the common status-register command set. It offers four operations: block erase, single-word program, lock-bit set and lock-bit clear. For each it writes the command words onto a word-wide bus master and then reads the device status repeatedly until the ready bit comes up or a cycle budget runs out. The final status byte becomes a result code. Before the result is reported, the device is always put back into read-array mode.

A client waits for `busy` to be low and then presents a request for one cycle. The request carries the operation, the target address, the data word and the poll budget in clock cycles. The client then waits for the one-cycle `res_valid` pulse and reads `res_code`. A program request first reads the target word. If any bit that the new value needs set is already cleared in the flash, the request is refused and nothing is written.

Top module: `nor_cmd_seq`

## Requirements
- R1: Erase (op 0) writes 0x0050, 0x0020, 0x00D0 to the request address on three consecutive bus write cycles. Each command byte sits in bits 7:0 and bits 15:8 are zero.
- R2: Program (op 1) first reads the target address. It then writes 0x0050, then 0x0040, then the request data word, all to the request address.
- R3: Lock set (op 2) writes 0x0050, 0x0060, 0x0001. Lock clear (op 3) writes 0x0050, 0x0060, 0x00D0.
- R4: If the program pre-read value P and data D satisfy (P & D) != D, the result is code 2 (not erased) and no bus write is made. When (P & D) == D the program proceeds.
- R5: After the command writes, status reads repeat on the request address until a read returns bit 7 set. Reads and writes never share a cycle.
- R6: Polling counts clock cycles from its first read. If a status read without bit 7 completes with the count at or above the limit, the result is code 1 (timeout). A read that shows bit 7 set wins over a limit reached on that same read. With limit 7, four status reads are made before a timeout.
- R7: A ready status whose low byte is exactly 0x80 gives code 0 (success).
- R8: For any other ready status: bits 5 and 4 both set give code 3 (sequence error), bit 5 alone gives code 4 (erase failure), and bit 4 alone gives code 5 (lock failure).
- R9: Status bit 1 set gives code 6 (locked block) and overrides the bit-5/4 class. Bit 3 gives code 7 (low programming voltage) only when bits 1, 4 and 5 are clear. Any other non-0x80 ready value gives code 8.
- R10: On every path except the code-2 refusal, the last bus write before `res_valid` is 0x00FF to the request address.
- R11: A request is taken only while `busy` is low. `busy` is high from the next cycle through the `res_valid` cycle, and `res_valid` lasts one cycle. Requests made while busy are ignored. `res_code` holds its value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 erase, 1 program, 2 lock set, 3 lock clear |
| req_addr | input | ADDR_W | Sector base or target word address |
| req_data | input | DATA_W | Word to program |
| req_limit | input | CNT_W | Poll budget in clock cycles |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 4 | Result code (see R4 to R9) |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | DATA_W | Flash write data |
| bus_we | output | 1 | Write strobe, one cycle per word |
| bus_re | output | 1 | Read strobe, data returned on the next cycle |
| bus_rdata | input | DATA_W | Flash read data |

## Verification
The ready detection and the timeout expiry can land on the same status read. That case is provoked by setting the limit to 7 and making the flash model raise bit 7 exactly on the fourth read, which is the read on which the count first reaches the limit. The result must be success, not timeout. Moving readiness one read later must give a timeout after exactly four reads, with the 0x00FF write still last.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE   = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_LOCK    = 2'd2,
        OP_UNLOCK  = 2'd3
    } nor_op_e;

    typedef enum logic [3:0] {
        RC_OK        = 4'd0,
        RC_TIMEOUT   = 4'd1,
        RC_NOT_ERASED= 4'd2,
        RC_SEQ_ERR   = 4'd3,
        RC_ERASE_ERR = 4'd4,
        RC_LOCK_ERR  = 4'd5,
        RC_LOCKED    = 4'd6,
        RC_LOW_VPP   = 4'd7,
        RC_OTHER     = 4'd8
    } nor_rc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WAIT,
        ST_CMD,
        ST_POLL_RD,
        ST_POLL_WAIT,
        ST_RESET,
        ST_DONE
    } nor_state_e;

    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PROG_SET   = 8'h40;
    localparam logic [7:0] CMD_LOCK_SET   = 8'h60;
    localparam logic [7:0] CMD_LOCK_ON    = 8'h01;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int STAT_READY  = 7;
    localparam int STAT_ERASE  = 5;
    localparam int STAT_LOCKB  = 4;
    localparam int STAT_VPP    = 3;
    localparam int STAT_PROT   = 1;

endpackage

// File: rtl/nor_cmd_word.sv
module nor_cmd_word
    import nor_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  nor_op_e           op,
    input  logic [1:0]        step,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - 8;

    logic [7:0] cmd;
    logic       use_data;

    always_comb begin
        cmd      = CMD_CLR_STATUS;
        use_data = 1'b0;
        case (step)
            2'd0: cmd = CMD_CLR_STATUS;
            2'd1: begin
                case (op)
                    OP_ERASE:   cmd = CMD_ERASE_SET;
                    OP_PROGRAM: cmd = CMD_PROG_SET;
                    default:    cmd = CMD_LOCK_SET;
                endcase
            end
            default: begin
                case (op)
                    OP_ERASE:   cmd = CMD_CONFIRM;
                    OP_PROGRAM: use_data = 1'b1;
                    OP_LOCK:    cmd = CMD_LOCK_ON;
                    default:    cmd = CMD_CONFIRM;
                endcase
            end
        endcase
        word = use_data ? data : {{PAD_W{1'b0}}, cmd};
    end

endmodule

// File: rtl/nor_status_decode.sv
module nor_status_decode
    import nor_seq_pkg::*;
(
    input  logic [7:0] status,
    output nor_rc_e    code
);
    logic erase_b;
    logic lock_b;

    assign erase_b = status[STAT_ERASE];
    assign lock_b  = status[STAT_LOCKB];

    always_comb begin
        if (status == 8'h80) begin
            code = RC_OK;
        end else if (status[STAT_PROT]) begin
            code = RC_LOCKED;
        end else if (erase_b && lock_b) begin
            code = RC_SEQ_ERR;
        end else if (erase_b) begin
            code = RC_ERASE_ERR;
        end else if (lock_b) begin
            code = RC_LOCK_ERR;
        end else if (status[STAT_VPP]) begin
            code = RC_LOW_VPP;
        end else begin
            code = RC_OTHER;
        end
    end

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  req_limit,
    output logic              busy,
    output logic              res_valid,
    output logic [3:0]        res_code,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int          PAD_W     = DATA_W - 8;
    localparam logic [1:0]  LAST_STEP = 2'd2;

    typedef struct packed {
        nor_state_e        state;
        logic [1:0]        step;
        nor_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  limit;
        nor_rc_e           code;
    } seq_t;

    seq_t q, d;

    logic [DATA_W-1:0] cmd_word;
    nor_rc_e           dec_code;
    logic              tmr_clear;
    logic              tmr_run;
    logic              tmr_expired;

    nor_cmd_word #(.DATA_W(DATA_W)) u_word (
        .op   (q.op),
        .step (q.step),
        .data (q.data),
        .word (cmd_word)
    );

    nor_status_decode u_dec (
        .status (bus_rdata[7:0]),
        .code   (dec_code)
    );

    nor_poll_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .limit   (q.limit),
        .expired (tmr_expired)
    );

    always_comb begin
        d         = q;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = '0;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        res_valid = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op    = nor_op_e'(req_op);
                    d.addr  = req_addr;
                    d.data  = req_data;
                    d.limit = req_limit;
                    d.step  = 2'd0;
                    d.state = (nor_op_e'(req_op) == OP_PROGRAM) ? ST_PRE_RD : ST_CMD;
                end
            end
            ST_PRE_RD: begin
                bus_re  = 1'b1;
                d.state = ST_PRE_WAIT;
            end
            ST_PRE_WAIT: begin
                if ((bus_rdata & q.data) != q.data) begin
                    d.code  = RC_NOT_ERASED;
                    d.state = ST_DONE;
                end else begin
                    d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                bus_we    = 1'b1;
                bus_wdata = cmd_word;
                tmr_clear = 1'b1;
                if (q.step == LAST_STEP) begin
                    d.state = ST_POLL_RD;
                end else begin
                    d.step = q.step + 2'd1;
                end
            end
            ST_POLL_RD: begin
                bus_re  = 1'b1;
                tmr_run = 1'b1;
                d.state = ST_POLL_WAIT;
            end
            ST_POLL_WAIT: begin
                tmr_run = 1'b1;
                if (bus_rdata[STAT_READY]) begin
                    d.code  = dec_code;
                    d.state = ST_RESET;
                end else if (tmr_expired) begin
                    d.code  = RC_TIMEOUT;
                    d.state = ST_RESET;
                end else begin
                    d.state = ST_POLL_RD;
                end
            end
            ST_RESET: begin
                bus_we    = 1'b1;
                bus_wdata = {{PAD_W{1'b0}}, CMD_READ_ARRAY};
                d.state   = ST_DONE;
            end
            ST_DONE: begin
                res_valid = 1'b1;
                d.state   = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.step  <= 2'd0;
            q.op    <= OP_ERASE;
            q.addr  <= '0;
            q.data  <= '0;
            q.limit <= '0;
            q.code  <= RC_OK;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state != ST_IDLE);
    assign res_code = q.code;
    assign bus_addr = q.addr;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              res_valid,
    input logic [3:0]        res_code,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_wdata
);
    localparam logic [DATA_W-1:0] READ_ARRAY_W = DATA_W'(8'hFF);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    p_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> busy);

    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_res_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    p_res_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && !busy));

    p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res_code));

    p_reset_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != 4'd2) |-> ($past(bus_we) && $past(bus_wdata) == READ_ARRAY_W));

    p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 4'd2) |-> !$past(bus_we));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .res_valid (res_valid),
    .res_code  (res_code),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [CW-1:0] req_limit = '0;
    logic          busy, res_valid;
    logic [3:0]    res_code;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we, bus_re;
    logic [DW-1:0] bus_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    // flash model controls and log
    logic          log_clr = 1'b0;
    int            ready_after = 1;
    logic [7:0]    final_st = 8'h80;
    logic [DW-1:0] array_word = 16'hFFFF;
    logic          array_mode = 1'b1;
    int            wr_n = 0;
    int            rd_n = 0;
    logic [DW-1:0] wr_dat [16];
    logic [AW-1:0] wr_adr [16];
    logic [3:0]    got_code;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_limit(req_limit),
        .busy(busy), .res_valid(res_valid), .res_code(res_code),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        if (log_clr) begin
            wr_n       <= 0;
            rd_n       <= 0;
            array_mode <= 1'b1;
        end else begin
            if (bus_we) begin
                wr_adr[wr_n % 16] <= bus_addr;
                wr_dat[wr_n % 16] <= bus_wdata;
                wr_n              <= wr_n + 1;
                array_mode        <= (bus_wdata == 16'h00FF);
            end
            if (bus_re) begin
                if (array_mode) begin
                    bus_rdata <= array_word;
                end else begin
                    rd_n      <= rd_n + 1;
                    bus_rdata <= (rd_n + 1 >= ready_after) ? {8'h00, final_st} : 16'h0000;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_seq(input string tag, input logic [AW-1:0] a, input int n,
                           input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                           input logic [DW-1:0] e2, input logic [DW-1:0] e3);
        logic [DW-1:0] ex [4];
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
        chk(wr_n == n, {tag, " write count"}, wr_n, n);
        for (int i = 0; i < n && i < 4; i++) begin
            chk(wr_dat[i] == ex[i], {tag, " write data"}, int'(wr_dat[i]), int'(ex[i]));
            chk(wr_adr[i] == a, {tag, " write addr"}, int'(wr_adr[i]), int'(a));
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                         input logic [CW-1:0] lim, input int rdy, input logic [7:0] fin,
                         input logic [DW-1:0] aw, input int hold_extra);
        int guard;
        ready_after = rdy;
        final_st    = fin;
        array_word  = aw;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dat; req_limit = lim;
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy after accept", busy, 1);
        if (hold_extra > 0) begin
            req_op = 2'd2; req_addr = a + 24'h100; req_data = 16'h0F0F;
            repeat (hold_extra) @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (!res_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(res_valid == 1'b1 && busy == 1'b1, "R11 result with busy", {res_valid, busy}, 3);
        got_code = res_code;
        @(negedge clk);
        chk(res_valid == 1'b0 && busy == 1'b0, "R11 single pulse then idle", {res_valid, busy}, 0);
        chk(res_code == got_code, "R11 code held", res_code, got_code);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R11 reset busy", busy, 0);
        chk(res_valid == 1'b0, "R11 reset res_valid", res_valid, 0);
        chk(bus_we == 1'b0 && bus_re == 1'b0, "R5 reset strobes", {bus_we, bus_re}, 0);
        chk(res_code == 4'd0, "R11 reset code", res_code, 0);
    endtask

    task automatic t_erase();
        do_op(2'd0, 24'h040000, 16'h0, 20'd100, 3, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd0, "R7 erase ok code", got_code, 0);
        chk_seq("R1 erase", 24'h040000, 4, 16'h0050, 16'h0020, 16'h00D0, 16'h00FF);
        chk(rd_n == 3, "R5 status read count", rd_n, 3);
    endtask

    task automatic t_program();
        do_op(2'd1, 24'h000123, 16'h1234, 20'd100, 2, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd0, "R2 program code", got_code, 0);
        chk_seq("R2 program", 24'h000123, 4, 16'h0050, 16'h0040, 16'h1234, 16'h00FF);
    endtask

    task automatic t_reject();
        do_op(2'd1, 24'h000200, 16'h1234, 20'd100, 1, 8'h80, 16'h00FF, 0);
        chk(got_code == 4'd2, "R4 not erased code", got_code, 2);
        chk(wr_n == 0, "R4 no writes on refusal", wr_n, 0);
        do_op(2'd1, 24'h000201, 16'h1234, 20'd100, 1, 8'h80, 16'hF3F4, 0);
        chk(got_code == 4'd0, "R4 partial word accepted", got_code, 0);
        chk_seq("R4 partial program", 24'h000201, 4, 16'h0050, 16'h0040, 16'h1234, 16'h00FF);
    endtask

    task automatic t_lock();
        do_op(2'd2, 24'h020000, 16'h0, 20'd100, 1, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd0, "R3 lock set code", got_code, 0);
        chk_seq("R3 lock set", 24'h020000, 4, 16'h0050, 16'h0060, 16'h0001, 16'h00FF);
        do_op(2'd3, 24'h030000, 16'h0, 20'd100, 1, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd0, "R3 lock clear code", got_code, 0);
        chk_seq("R3 lock clear", 24'h030000, 4, 16'h0050, 16'h0060, 16'h00D0, 16'h00FF);
    endtask

    task automatic t_classify();
        logic [7:0] sts [7];
        logic [3:0] exp [7];
        sts[0] = 8'hB0; exp[0] = 4'd3;
        sts[1] = 8'hA0; exp[1] = 4'd4;
        sts[2] = 8'h90; exp[2] = 4'd5;
        sts[3] = 8'hB2; exp[3] = 4'd6;
        sts[4] = 8'h88; exp[4] = 4'd7;
        sts[5] = 8'h81; exp[5] = 4'd8;
        sts[6] = 8'h98; exp[6] = 4'd5;
        for (int i = 0; i < 7; i++) begin
            do_op(2'd0, 24'h050000, 16'h0, 20'd100, 2, sts[i], 16'hFFFF, 0);
            chk(got_code == exp[i], (i == 3 || i == 4 || i == 5) ? "R9 status class" : "R8 status class",
                got_code, exp[i]);
            chk(wr_n == 4 && wr_dat[3] == 16'h00FF, "R10 reset after error", int'(wr_dat[3]), 16'h00FF);
        end
    endtask

    task automatic t_timeout();
        do_op(2'd0, 24'h060000, 16'h0, 20'd7, 5, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd1, "R6 timeout code", got_code, 1);
        chk(rd_n == 4, "R6 reads before timeout", rd_n, 4);
        chk(wr_n == 4 && wr_dat[3] == 16'h00FF, "R10 reset after timeout", int'(wr_dat[3]), 16'h00FF);
        do_op(2'd0, 24'h060000, 16'h0, 20'd7, 4, 8'h80, 16'hFFFF, 0);
        chk(got_code == 4'd0, "R6 ready wins same read", got_code, 0);
        chk(rd_n == 4, "R6 reads when ready at limit", rd_n, 4);
    endtask

    task automatic t_busy_ignore();
        do_op(2'd0, 24'h070000, 16'h0, 20'd100, 2, 8'h80, 16'hFFFF, 3);
        chk(got_code == 4'd0, "R11 first request result", got_code, 0);
        chk_seq("R11 busy request ignored", 24'h070000, 4, 16'h0050, 16'h0020, 16'h00D0, 16'h00FF);
        @(negedge clk);
        chk(busy == 1'b0, "R11 stays idle", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_erase();
        t_program();
        t_reject();
        t_lock();
        t_classify();
        t_timeout();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule